// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address of each beat of a four-beat burst. A start strobe captures a full word address. The two low bits of that address are the starting offset of the burst. Each advance request then moves the low bits to the next beat. The upper bits keep the captured value until the next start.

A static order input picks between two beat orders. With the order input high, the offset is the start offset XOR the beat number. This suits processors that fill cache lines in that order. With the order input low, the offset is the start offset plus the beat number, modulo four. In both orders the sequence keeps going past the fourth beat and comes back to the start offset.

The address and the beat number come straight from flops, so a memory array can use them directly as a registered address.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, `addr_o` and `beat_o` become zero at that edge.
- R2: A rising edge with `start_i` high loads `start_addr_i` into `addr_o` and clears `beat_o` to 0. This happens even when `adv_i` is also high, and takes effect at that same edge.
- R3: With `ilv_i` = 1 (interleaved order), `addr_o[1:0]` equals the start offset XOR `beat_o`. From start offsets 0, 1, 2 and 3 the sequences are 0-1-2-3, 1-0-3-2, 2-3-0-1 and 3-2-1-0.
- R4: With `ilv_i` = 0 (linear order), `addr_o[1:0]` equals (start offset + `beat_o`) mod 4. For example, start offset 2 gives 2-3-0-1.
- R5: A rising edge with `adv_i` high and `start_i` low increments `beat_o` by one, modulo 4.
- R6: A rising edge with both `start_i` and `adv_i` low leaves `addr_o` and `beat_o` unchanged.
- R7: `addr_o[ADDR_W-1:2]` keeps the value it was loaded with across every advance and hold, until the next start.
- R8: An advance taken from beat 3 returns `beat_o` to 0 and `addr_o` to the loaded start address. The burst does not stop there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ilv_i | input | 1 | Beat order: 1 = interleaved, 0 = linear; static outside reset |
| start_i | input | 1 | Begin a burst at `start_addr_i` |
| start_addr_i | input | ADDR_W | Start address of the burst |
| adv_i | input | 1 | Step to the next beat |
| addr_o | output | ADDR_W | Registered address of the current beat |
| beat_o | output | OFS_W | Registered beat number within the burst |

## Verification
The assertions check four things on every cycle:
- a start loads the address and clears the beat;
- an idle cycle changes nothing;
- each advance steps the beat by exactly one;
- the upper address bits stay put.

They also check that the low output bits match the selected order when compared with the stored start offset. Only the bench's scenarios show the actual offset sequences for each of the four start offsets in both orders, including the wrap back to the start after beat 3. The bench also covers the reset values and the case where start and advance arrive in the same cycle.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } beat_order_e;
endpackage

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] base_nxt
);
  always_comb base_nxt = load ? addr_in : base_q;

  always_ff @(posedge clk) begin
    if (rst) base_q <= '0;
    else     base_q <= base_nxt;
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R7: without a load the stored start address never moves
  p_base_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && !$past(load)) |-> $stable(base_q));
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int OFS_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             step,
  output logic [OFS_W-1:0] beat_q,
  output logic [OFS_W-1:0] beat_nxt
);
  always_comb begin
    if (clr)       beat_nxt = '0;
    else if (step) beat_nxt = beat_q + OFS_W'(1);
    else           beat_nxt = beat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) beat_q <= '0;
    else     beat_q <= beat_nxt;
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  // R5 / R8: one step per advance, wrapping modulo the burst length
  p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $past(step) && !$past(clr))
      |-> beat_q == OFS_W'($past(beat_q) + 1'b1));
  // R2: a start always clears the beat
  p_beat_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $past(clr)) |-> beat_q == '0);
endmodule

// File: rtl/burst_ofs_map.sv
module burst_ofs_map
  import burst_seq_pkg::*;
#(
  parameter int OFS_W = 2
) (
  input  beat_order_e      order,
  input  logic [OFS_W-1:0] base_ofs,
  input  logic [OFS_W-1:0] beat,
  output logic [OFS_W-1:0] ofs
);
  logic [OFS_W-1:0] ofs_xor;
  logic [OFS_W-1:0] ofs_add;

  for (genvar b = 0; b < OFS_W; b++) begin : g_xor
    assign ofs_xor[b] = base_ofs[b] ^ beat[b];
  end

  assign ofs_add = base_ofs + beat;

  always_comb ofs = (order == ORD_INTERLEAVE) ? ofs_xor : ofs_add;
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int OFS_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ilv_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFS_W-1:0]  beat_o
);
  localparam int UP_W = ADDR_W - OFS_W;

  beat_order_e      order;
  logic [ADDR_W-1:0] base_q, base_nxt;
  logic [OFS_W-1:0]  beat_q, beat_nxt;
  logic [OFS_W-1:0]  ofs_nxt;
  logic [ADDR_W-1:0] addr_q;

  assign order = beat_order_e'(ilv_i);

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk(clk), .rst(rst), .load(start_i), .addr_in(start_addr_i),
    .base_q(base_q), .base_nxt(base_nxt)
  );

  burst_beat_ctr #(.OFS_W(OFS_W)) u_beat (
    .clk(clk), .rst(rst), .clr(start_i), .step(adv_i),
    .beat_q(beat_q), .beat_nxt(beat_nxt)
  );

  burst_ofs_map #(.OFS_W(OFS_W)) u_map (
    .order(order), .base_ofs(base_nxt[OFS_W-1:0]), .beat(beat_nxt), .ofs(ofs_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= {base_nxt[ADDR_W-1:OFS_W], ofs_nxt};
  end

  assign addr_o = addr_q;
  assign beat_o = beat_q;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $past(start_i))
      |-> (addr_o == $past(start_addr_i) && beat_o == '0));
  p_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && !$past(start_i) && !$past(adv_i))
      |-> ($stable(addr_o) && $stable(beat_o)));
  p_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && !$past(start_i))
      |-> $stable(addr_o[ADDR_W-1:OFS_W]));
  p_ilv_map_r3: assert property (@(posedge clk) disable iff (rst)
    ilv_i |-> ((addr_o[OFS_W-1:0] ^ beat_o) == base_q[OFS_W-1:0]));
  p_lin_map_r4: assert property (@(posedge clk) disable iff (rst)
    !ilv_i |-> (OFS_W'(addr_o[OFS_W-1:0] - beat_o) == base_q[OFS_W-1:0]));

  if (UP_W < 1) begin : g_bad_width
    initial $error("ADDR_W must exceed OFS_W");
  end
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int ADDR_W = 15;
  localparam int OFS_W  = 2;

  logic              clk = 1'b0;
  logic              rst;
  logic              ilv_i;
  logic              start_i;
  logic [ADDR_W-1:0] start_addr_i;
  logic              adv_i;
  logic [ADDR_W-1:0] addr_o;
  logic [OFS_W-1:0]  beat_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) dut (
    .clk(clk), .rst(rst), .ilv_i(ilv_i), .start_i(start_i),
    .start_addr_i(start_addr_i), .adv_i(adv_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ofs_of(input logic ilv, input logic [1:0] s, input logic [1:0] k);
    return ilv ? (s ^ k) : 2'(s + k);
  endfunction

  task automatic cyc(input logic st, input logic [ADDR_W-1:0] a, input logic av);
    @(negedge clk);
    start_i = st; start_addr_i = a; adv_i = av;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic ilv);
    @(negedge clk);
    rst = 1'b1; ilv_i = ilv; start_i = 1'b0; adv_i = 1'b0; start_addr_i = '0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 addr", 32'(addr_o), 0);
    chk("R1 beat", 32'(beat_o), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_order(input logic ilv);
    do_reset(ilv);
    for (int s = 0; s < 4; s++) begin
      logic [ADDR_W-1:0] a;
      a = {13'h1a5 + 13'(s * 7), 2'(s)};
      cyc(1'b1, a, 1'b0);
      chk("R2 load", 32'(addr_o), 32'(a));
      for (int k = 1; k < 5; k++) begin
        cyc(1'b0, '0, 1'b1);
        chk("R5 beat", 32'(beat_o), 32'(k % 4));
        chk(ilv ? "R3 ofs" : "R4 ofs", 32'(addr_o[1:0]),
            32'(ofs_of(ilv, 2'(s), 2'(k % 4))));
        chk("R7 upper", 32'(addr_o[ADDR_W-1:2]), 32'(a[ADDR_W-1:2]));
      end
      chk("R8 wrap", 32'(addr_o), 32'(a));
    end
  endtask

  task automatic t_hold;
    logic [ADDR_W-1:0] a;
    do_reset(1'b0);
    a = 15'h5a73;
    cyc(1'b1, a, 1'b0);
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, 15'h7fff, 1'b0);
    chk("R6 beat", 32'(beat_o), 1);
    chk("R6 addr", 32'({a[ADDR_W-1:2], 2'(a[1:0] + 2'd1)}), 32'(addr_o));
    cyc(1'b0, '0, 1'b0);
    chk("R6 addr2", 32'(addr_o), 32'({a[ADDR_W-1:2], 2'(a[1:0] + 2'd1)}));
  endtask

  task automatic t_start_overrides;
    logic [ADDR_W-1:0] a;
    do_reset(1'b1);
    cyc(1'b1, 15'h0001, 1'b0);
    cyc(1'b0, '0, 1'b1);
    cyc(1'b0, '0, 1'b1);
    a = 15'h3ffe;
    cyc(1'b1, a, 1'b1);
    chk("R2 override addr", 32'(addr_o), 32'(a));
    chk("R2 override beat", 32'(beat_o), 0);
    cyc(1'b0, '0, 1'b1);
    chk("R3 after override", 32'(addr_o), 32'({a[ADDR_W-1:2], 2'b11}));
  endtask

  initial begin
    rst = 1'b1; ilv_i = 1'b0; start_i = 1'b0; adv_i = 1'b0; start_addr_i = '0;
    t_order(1'b1);
    t_order(1'b0);
    t_hold();
    t_start_overrides();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule